// File: doc/BRIEF.md
# GPIO Interrupt Channel Multiplexer

The block picks one pad line out of a wide bank of asynchronous pad inputs for each of eight interrupt channels and turns it into a signal that a simple downstream interrupt controller can take. That controller only needs to understand active-high levels or rising-edge pulses. Each channel brings its chosen pad into the clock domain through a two-flop synchronizer. It can invert the pad, run it through a stable-sample glitch filter, and then present it as a level, a single-clock pulse on each rising edge, or a single-clock pulse on every transition. This lets falling-edge and active-low sources be served by a controller that has no notion of either.

Software sets the block up through a small register port. Each access takes one cycle: an address, a write enable, write data and combinational read data, with no handshake. Whenever a channel's source selector or trigger settings are rewritten, the channel's edge history is reloaded from the new input, so the change itself cannot raise an interrupt.

Top module: `gpio_irq_mux`

## Requirements
- R1: After reset every configuration register reads zero: all channels are in level mode, not inverted, unfiltered and selecting pad 0. The interrupt outputs are low while the selected pads are low.
- R2: Register map with 32-bit words. Offset 0x0 holds the trigger controls: edge mode for channel c at bit c, any-edge mode at bit 8+c, inversion at bit 16+c, and bits 31:24 read as zero. Offset 0x4 holds the 8-bit selectors of channels 0 to 3, with channel c at bit 8*c. Offset 0x8 holds channels 4 to 7, with channel c at bit 8*(c-4). Offset 0xC holds a 4-bit filter length per channel at bit 4*c. A write to any other address changes nothing, and a read of one returns zero.
- R3: In level mode, with filter length 0, the output follows the selected pad three clock edges after the pad changes.
- R4: When the inversion bit is set in level or edge mode, the selected pad is inverted before filtering, so a low pad yields a high output.
- R5: In edge mode, each rising transition of the (possibly inverted) filtered input gives exactly one single-cycle high pulse, and a falling transition gives none.
- R6: In any-edge mode, every transition of the filtered input gives exactly one single-cycle pulse, whatever the edge-mode and inversion bits hold.
- R7: A filter length N of at least 1 accepts a new input value only after N consecutive synchronized samples of that value, so a level change reaches the output N+2 edges after the pad changes. A pulse shorter than N samples is dropped, and N=0 bypasses the filter.
- R8: Rewriting a channel's selector word or the trigger word never produces a pulse on an edge-mode channel merely because the new source or polarity differs from the old one.
- R9: Channels work independently, and any number of channels may select the same pad with different settings at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | 4 | Byte address of the register being accessed |
| cfg_wr | input | 1 | Write enable, one cycle per write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, combinational |
| pad_in | input | N_IN | Asynchronous pad lines |
| irq_out | output | 8 | Active-high interrupt level or pulse per channel |

## Verification
The pulse-width assertions take for granted that configuration changes arrive only through the register port. They also assume a channel in any-edge mode that is expected to give isolated pulses has a filter length of at least two. With no filter, a pad toggling every cycle legitimately makes back-to-back pulses, so that case is excluded from the property rather than from the design. The filter assertion assumes nothing about the pads. The stimulus holds every pad value for far longer than the longest filter length plus the synchronizer depth, and it changes configuration only while the pads are still. The one exception is the deliberate short glitch aimed at the filter.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int CH_NUM = 8;
  localparam int SEL_W  = 8;
  localparam int FILT_W = 4;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  localparam int EDGE_LSB = 0;
  localparam int ANY_LSB  = 8;
  localparam int INV_LSB  = 16;

  localparam logic [ADDR_W-1:0] OFF_TRIG   = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_SEL_LO = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_SEL_HI = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_FILT   = 4'hC;

  localparam int HALF_CH  = CH_NUM / 2;
  localparam int SEL_HALF = HALF_CH * SEL_W;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_RISE  = 2'd1,
    TRIG_ANY   = 2'd2
  } trig_e;

  function automatic trig_e trig_decode(input logic rise_en, input logic any_en);
    if (any_en) return TRIG_ANY;
    if (rise_en) return TRIG_RISE;
    return TRIG_LEVEL;
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import gpio_irq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     wr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [CH_NUM-1:0]        rise_o,
  output logic [CH_NUM-1:0]        any_o,
  output logic [CH_NUM-1:0]        inv_o,
  output logic [CH_NUM*SEL_W-1:0]  sel_o,
  output logic [CH_NUM*FILT_W-1:0] filt_o,
  output logic [CH_NUM-1:0]        reload_o
);
  logic [CH_NUM-1:0]        rise_q, any_q, inv_q;
  logic [CH_NUM*SEL_W-1:0]  sel_q;
  logic [CH_NUM*FILT_W-1:0] filt_q;

  logic hit_trig, hit_lo, hit_hi, hit_filt;
  assign hit_trig = wr_i && (addr_i == OFF_TRIG);
  assign hit_lo   = wr_i && (addr_i == OFF_SEL_LO);
  assign hit_hi   = wr_i && (addr_i == OFF_SEL_HI);
  assign hit_filt = wr_i && (addr_i == OFF_FILT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      any_q  <= '0;
      inv_q  <= '0;
      sel_q  <= '0;
      filt_q <= '0;
    end else begin
      if (hit_trig) begin
        rise_q <= wdata_i[EDGE_LSB +: CH_NUM];
        any_q  <= wdata_i[ANY_LSB  +: CH_NUM];
        inv_q  <= wdata_i[INV_LSB  +: CH_NUM];
      end
      if (hit_lo)   sel_q[0 +: SEL_HALF]        <= wdata_i[SEL_HALF-1:0];
      if (hit_hi)   sel_q[SEL_HALF +: SEL_HALF] <= wdata_i[SEL_HALF-1:0];
      if (hit_filt) filt_q <= wdata_i[CH_NUM*FILT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_TRIG: begin
        rdata_o[EDGE_LSB +: CH_NUM] = rise_q;
        rdata_o[ANY_LSB  +: CH_NUM] = any_q;
        rdata_o[INV_LSB  +: CH_NUM] = inv_q;
      end
      OFF_SEL_LO: rdata_o[SEL_HALF-1:0] = sel_q[0 +: SEL_HALF];
      OFF_SEL_HI: rdata_o[SEL_HALF-1:0] = sel_q[SEL_HALF +: SEL_HALF];
      OFF_FILT:   rdata_o[CH_NUM*FILT_W-1:0] = filt_q;
      default:    rdata_o = '0;
    endcase
  end

  for (genvar c = 0; c < CH_NUM; c++) begin : g_reload
    if (c < HALF_CH) begin : g_lo
      assign reload_o[c] = hit_trig || hit_lo;
    end else begin : g_hi
      assign reload_o[c] = hit_trig || hit_hi;
    end
  end

  assign rise_o = rise_q;
  assign any_o  = any_q;
  assign inv_o  = inv_q;
  assign sel_o  = sel_q;
  assign filt_o = filt_q;

  // R2: a filter-word write lands in the filter fields on the next cycle
  a_r2_filt_write: assert property (@(posedge clk) disable iff (!rst_n)
    hit_filt |=> (filt_o == $past(wdata_i[CH_NUM*FILT_W-1:0])));

  // R2: a low selector-word write lands in channels 0..3
  a_r2_sel_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
    hit_lo |=> (sel_o[SEL_HALF-1:0] == $past(wdata_i[SEL_HALF-1:0])));
endmodule

// File: rtl/irq_glitch_filter.sv
module irq_glitch_filter #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [FW-1:0] limit_i,
  input  logic          d_i,
  output logic          q_o
);
  logic [FW-1:0] run_q;
  logic          q_q;
  logic [FW:0]   run_inc;

  assign run_inc = {1'b0, run_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= 1'b0;
      run_q <= '0;
    end else if (load_i || (limit_i == '0)) begin
      q_q   <= d_i;
      run_q <= '0;
    end else if (d_i == q_q) begin
      run_q <= '0;
    end else if (run_inc >= {1'b0, limit_i}) begin
      q_q   <= d_i;
      run_q <= '0;
    end else begin
      run_q <= run_inc[FW-1:0];
    end
  end

  assign q_o = q_q;

  // R7: with a limit of two or more, an accepted change was seen on the two prior samples
  a_r7_filter_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_i) && !$past(load_i, 2) && ($past(limit_i) >= 2) && (q_q != $past(q_q)))
      |-> ((q_q == $past(d_i)) && (q_q == $past(d_i, 2))));
endmodule

// File: rtl/irq_chan.sv
module irq_chan
  import gpio_irq_pkg::*;
#(
  parameter int N_IN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   pad_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              rise_i,
  input  logic              any_i,
  input  logic              inv_i,
  input  logic [FILT_W-1:0] filt_i,
  input  logic              reload_i,
  output logic              irq_o
);
  localparam int SYNC_STAGES = 2;
  localparam int QUIET_LEN   = SYNC_STAGES + 1;
  localparam int QW          = $clog2(QUIET_LEN + 1);

  logic picked;
  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (SEL_W'(i) == sel_i) picked = pad_i[i];
    end
  end

  logic [SYNC_STAGES-1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], picked};
  end

  trig_e mode;
  assign mode = trig_decode(rise_i, any_i);

  logic polar;
  assign polar = sync_q[SYNC_STAGES-1] ^ (inv_i & (mode != TRIG_ANY));

  logic [QW-1:0] quiet_q;
  logic          quiet;
  assign quiet = (quiet_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        quiet_q <= '0;
    else if (reload_i) quiet_q <= QW'(QUIET_LEN);
    else if (quiet)    quiet_q <= quiet_q - 1'b1;
  end

  logic filt_val;
  irq_glitch_filter #(.FW(FILT_W)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (quiet),
    .limit_i (filt_i),
    .d_i     (polar),
    .q_o     (filt_val)
  );

  logic hist_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hist_q <= 1'b0;
    else if (quiet) hist_q <= polar;
    else            hist_q <= filt_val;
  end

  always_comb begin
    unique case (mode)
      TRIG_RISE: irq_o = !quiet && filt_val && !hist_q;
      TRIG_ANY:  irq_o = !quiet && (filt_val != hist_q);
      default:   irq_o = filt_val;
    endcase
  end

  // R5: an edge-mode pulse lasts exactly one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == TRIG_RISE) && irq_o && !reload_i) |=> !irq_o);

  // R6: any-edge pulses are isolated when the filter spaces transitions
  a_r6_any_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == TRIG_ANY) && irq_o && !reload_i && (filt_i >= 2)) |=> !irq_o);
endmodule

// File: rtl/gpio_irq_mux.sv
module gpio_irq_mux
  import gpio_irq_pkg::*;
#(
  parameter int N_IN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [N_IN-1:0]   pad_in,
  output logic [CH_NUM-1:0] irq_out
);
  logic [CH_NUM-1:0]        rise_v, any_v, inv_v, reload_v;
  logic [CH_NUM*SEL_W-1:0]  sel_v;
  logic [CH_NUM*FILT_W-1:0] filt_v;

  irq_cfg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (cfg_addr),
    .wr_i     (cfg_wr),
    .wdata_i  (cfg_wdata),
    .rdata_o  (cfg_rdata),
    .rise_o   (rise_v),
    .any_o    (any_v),
    .inv_o    (inv_v),
    .sel_o    (sel_v),
    .filt_o   (filt_v),
    .reload_o (reload_v)
  );

  for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
    irq_chan #(.N_IN(N_IN)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .pad_i    (pad_in),
      .sel_i    (sel_v[c*SEL_W +: SEL_W]),
      .rise_i   (rise_v[c]),
      .any_i    (any_v[c]),
      .inv_i    (inv_v[c]),
      .filt_i   (filt_v[c*FILT_W +: FILT_W]),
      .reload_i (reload_v[c]),
      .irq_o    (irq_out[c])
    );
  end
endmodule

// File: tb/tb_gpio_irq_mux.sv
module tb_gpio_irq_mux;
  localparam int CLK_PERIOD = 10;
  localparam int NIN = 256;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [3:0]     cfg_addr = '0;
  logic           cfg_wr = 1'b0;
  logic [31:0]    cfg_wdata = '0;
  logic [31:0]    cfg_rdata;
  logic [NIN-1:0] pad = '0;
  logic [7:0]     irq;

  int n_chk = 0;
  int n_err = 0;
  int cnt [8];

  bit [7:0] sh_rise, sh_any, sh_inv;
  bit [7:0] sh_sel [8];
  bit [3:0] sh_filt [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_mux #(.N_IN(NIN)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pad_in(pad), .irq_out(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_pulses(bit o, bit n, bit inv, bit r, bit a);
    if (a) return (o != n) ? 1 : 0;
    if (r) return (!(o ^ inv) && (n ^ inv)) ? 1 : 0;
    return 0;
  endfunction

  function automatic bit exp_level(bit v, bit inv);
    return v ^ inv;
  endfunction

  function automatic logic [31:0] trig_word();
    return {8'h00, sh_inv, sh_any, sh_rise};
  endfunction

  function automatic logic [31:0] sel_word(int base);
    return {sh_sel[base+3], sh_sel[base+2], sh_sel[base+1], sh_sel[base]};
  endfunction

  function automatic logic [31:0] filt_word();
    logic [31:0] w = '0;
    for (int c = 0; c < 8; c++) w[c*4 +: 4] = sh_filt[c];
    return w;
  endfunction

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic push_cfg();
    wr_reg(4'h0, trig_word());
    wr_reg(4'h4, sel_word(0));
    wr_reg(4'h8, sel_word(4));
    wr_reg(4'hC, filt_word());
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_cnt();
    for (int c = 0; c < 8; c++) cnt[c] = 0;
  endtask

  task automatic observe(input int n);
    repeat (n) begin
      @(negedge clk);
      for (int c = 0; c < 8; c++) cnt[c] += int'(irq[c]);
    end
  endtask

  task automatic clear_shadow();
    sh_rise = '0; sh_any = '0; sh_inv = '0;
    for (int c = 0; c < 8; c++) begin sh_sel[c] = '0; sh_filt[c] = '0; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [15:0] old_p, new_p;
    void'($urandom(32'h1234_abcd));
    clear_shadow();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle(2);

    // R1: reset state
    rd_reg(4'h0, d); check("R1 trig", d, 32'h0);
    rd_reg(4'h4, d); check("R1 sel_lo", d, 32'h0);
    rd_reg(4'h8, d); check("R1 sel_hi", d, 32'h0);
    rd_reg(4'hC, d); check("R1 filt", d, 32'h0);
    check("R1 irq", {24'h0, irq}, 32'h0);

    // R2: register map and readback
    wr_reg(4'h0, 32'hFFFF_FFFF); rd_reg(4'h0, d); check("R2 trig", d, 32'h00FF_FFFF);
    wr_reg(4'h4, 32'h0403_0201); rd_reg(4'h4, d); check("R2 sel_lo", d, 32'h0403_0201);
    wr_reg(4'h8, 32'h0C0B_0A09); rd_reg(4'h8, d); check("R2 sel_hi", d, 32'h0C0B_0A09);
    wr_reg(4'hC, 32'h7654_3210); rd_reg(4'hC, d); check("R2 filt", d, 32'h7654_3210);
    wr_reg(4'h2, 32'hDEAD_BEEF); rd_reg(4'h2, d); check("R2 unmapped read", d, 32'h0);
    rd_reg(4'hC, d); check("R2 unmapped write no effect", d, 32'h7654_3210);
    rd_reg(4'h4, d); check("R2 sel_lo kept", d, 32'h0403_0201);
    clear_shadow(); push_cfg(); settle(8);

    // R3: level latency
    sh_sel[0] = 8'd5; push_cfg(); settle(8);
    @(negedge clk); pad[5] = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R3 not yet", {31'h0, irq[0]}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R3 level high", {31'h0, irq[0]}, 32'h1);
    pad[5] = 1'b0; settle(6);
    check("R3 level low", {31'h0, irq[0]}, 32'h0);

    // R4: inverted level
    sh_sel[1] = 8'd5; sh_inv[1] = 1'b1; push_cfg(); settle(8);
    check("R4 low pad high out", {31'h0, irq[1]}, 32'h1);
    pad[5] = 1'b1; settle(6);
    check("R4 high pad low out", {31'h0, irq[1]}, 32'h0);
    pad[5] = 1'b0; settle(6);

    // R5: rising-edge pulses
    sh_sel[2] = 8'd7; sh_rise[2] = 1'b1; push_cfg(); settle(8);
    clr_cnt(); pad[7] = 1'b1; observe(10);
    check("R5 rise one pulse", cnt[2], 1);
    clr_cnt(); pad[7] = 1'b0; observe(10);
    check("R5 fall no pulse", cnt[2], 0);
    sh_inv[2] = 1'b1; push_cfg(); settle(8);
    clr_cnt(); pad[7] = 1'b1; observe(10);
    check("R5 R4 inverted rise none", cnt[2], 0);
    clr_cnt(); pad[7] = 1'b0; observe(10);
    check("R5 R4 inverted fall pulse", cnt[2], 1);
    sh_inv[2] = 1'b0; push_cfg(); settle(8);

    // R6: any-edge ignores inversion and edge bit
    sh_sel[3] = 8'd8; sh_any[3] = 1'b1; sh_inv[3] = 1'b1; sh_rise[3] = 1'b1;
    push_cfg(); settle(8);
    clr_cnt(); pad[8] = 1'b1; observe(10);
    check("R6 rise pulse", cnt[3], 1);
    clr_cnt(); pad[8] = 1'b0; observe(10);
    check("R6 fall pulse", cnt[3], 1);

    // R7: filter
    sh_filt[0] = 4'd4; push_cfg(); settle(8);
    clr_cnt(); pad[5] = 1'b1; observe(3); pad[5] = 1'b0; observe(12);
    check("R7 glitch dropped", cnt[0], 0);
    @(negedge clk); pad[5] = 1'b1;
    repeat (5) @(posedge clk); @(negedge clk);
    check("R7 before N+2", {31'h0, irq[0]}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R7 at N+2", {31'h0, irq[0]}, 32'h1);
    pad[5] = 1'b0; settle(10);

    // R8: reconfiguration makes no pulse
    pad[7] = 1'b1; pad[9] = 1'b0; settle(8);
    sh_sel[2] = 8'd9; wr_reg(4'h4, sel_word(0)); settle(8);
    clr_cnt(); sh_sel[2] = 8'd7; wr_reg(4'h4, sel_word(0)); observe(12);
    check("R8 selector change", cnt[2], 0);
    sh_sel[4] = 8'd7; sh_inv[4] = 1'b1; push_cfg(); settle(8);
    clr_cnt(); sh_rise[4] = 1'b1; sh_inv[4] = 1'b0; wr_reg(4'h0, trig_word()); observe(12);
    check("R8 mode change", cnt[4], 0);
    clr_cnt(); pad[7] = 1'b0; observe(8); pad[7] = 1'b1; observe(8);
    check("R8 still live", cnt[4], 1);

    // R9: random shared and independent channels
    for (int it = 0; it < 30; it++) begin
      for (int c = 0; c < 8; c++) begin
        int m;
        m = int'($urandom % 3);
        sh_rise[c] = (m == 1);
        sh_any[c]  = (m == 2);
        sh_inv[c]  = 1'($urandom);
        sh_sel[c]  = 8'($urandom % 16);
        sh_filt[c] = 4'($urandom % 4);
      end
      push_cfg(); settle(10);
      old_p = pad[15:0];
      new_p = 16'($urandom);
      clr_cnt();
      pad[15:0] = new_p;
      observe(20);
      for (int c = 0; c < 8; c++) begin
        if (!sh_rise[c] && !sh_any[c])
          check("R9 R3 level", {31'h0, irq[c]},
                {31'h0, exp_level(new_p[sh_sel[c]], sh_inv[c])});
        else
          check("R9 R5 R6 pulses", cnt[c],
                exp_pulses(old_p[sh_sel[c]], new_p[sh_sel[c]], sh_inv[c],
                           sh_rise[c], sh_any[c]));
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule